// File: doc/BRIEF.md
# Lazy Release Page-List Tracker

This block keeps the coherence bookkeeping for a small shared-memory system that defers cache invalidation until a lock is taken. For every page it holds one access code per processor (none, read, write), a count of the processors holding any access, and one flag saying whether the page is currently both shared and written. Page faults raise a processor's access and may flag the page. An acquire walks the flagged pages and strips the acquiring processor of every flagged page it can touch. The caches are told which lines to drop through an invalidate request/acknowledge pair.

Commands arrive one at a time on a valid/ready port with an operation code, a processor index and a page index. Each command is answered by a single-cycle done pulse. A release only waits until the named processor reports that its write buffer is empty. The access codes, counters and flags are driven out as flat vectors, so the page tables can mirror them.

Top module: `lrc_page_tracker`

## Requirements
- R1: After reset every access code is none (0), every page count is zero, no page is flagged, `cmd_ready` is high and `busy` is low.
- R2: A read fault (op 0) from a processor whose access to the page is none sets its code to read (1) and adds one to the page count. The page becomes flagged if another processor holds write (2) on it; otherwise the flag keeps its value.
- R3: A read fault from a processor that already holds read or write on that page changes no code, count or flag.
- R4: A write fault (op 1) sets the requester's code to write (2). It adds one to the count only when the requester's code was none; an upgrade from read leaves the count unchanged.
- R5: After a write fault, the page is flagged when its count is greater than one. With a count of one, the flag keeps its value.
- R6: A fault accepted at a clock edge has its new state on the outputs after that edge. `cmd_done` pulses for exactly one cycle, in the cycle after acceptance.
- R7: On an acquire (op 2), `inv_req` is raised with `inv_proc` set to the acquirer, once for each flagged page on which the acquirer's code is not none. Pages are visited in ascending order, and every other page is skipped. `inv_page` is held stable until `inv_ack`.
- R8: At the edge where `inv_ack` is high, the acquirer's code for that page becomes none and the page count drops by one. The flag is cleared if the count reaches zero.
- R9: `busy` is high from the cycle after an acquire is accepted until the scan ends. `cmd_done` for the acquire follows only after the last acknowledge, in a cycle where `busy` is low.
- R10: A release (op 3) changes no state. Its `cmd_done` appears only after `wb_empty` of that processor has been sampled high.
- R11: Flagging a page that is already flagged leaves the flag set, with no other effect on the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 2 | 0 read fault, 1 write fault, 2 acquire, 3 release |
| cmd_proc | input | PW | Requesting processor |
| cmd_page | input | GW | Page for faults |
| cmd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Acquire scan in progress |
| inv_req | output | 1 | Invalidate-and-revoke request |
| inv_proc | output | PW | Processor whose lines are dropped |
| inv_page | output | GW | Page whose lines are dropped |
| inv_ack | input | 1 | Invalidation finished |
| wb_empty | input | NPROC | Per-processor write buffer empty |
| perm_o | output | 2*NPAGE*NPROC | Access code of processor p on page g at bits (g*NPROC+p)*2 +: 2 |
| list_o | output | NPAGE | Shared-and-written flag per page |
| cnt_o | output | NPAGE*CW | Holder count of page g at bits g*CW +: CW |

## Verification
A fault's new codes, counts and flags appear after the accepting edge, and its done pulse is due one cycle later. The bench compares the whole state in that cycle and fails any fault whose pulse arrives later. During an acquire the bench samples at every falling edge: each request is matched against the next page of a list computed beforehand, its page must stay stable until a randomly delayed acknowledge, and `busy` must be high until the pulse. A release's pulse is only legal after the bench has raised the write-buffer flag it lowered beforehand, so an early completion is caught.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    OP_RDF = 2'd0,
    OP_WRF = 2'd1,
    OP_ACQ = 2'd2,
    OP_REL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PR_NIL   = 2'd0,
    PR_READ  = 2'd1,
    PR_WRITE = 2'd2
  } perm_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RESP   = 3'd1,
    S_WAITWB = 3'd2,
    S_SCAN   = 3'd3,
    S_INV    = 3'd4
  } state_e;
endpackage

// File: rtl/lrc_page_slot.sv
module lrc_page_slot
  import lrc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_hit,
  input  logic                 wr_hit,
  input  logic                 rv_hit,
  input  logic [PW-1:0]        proc,
  output logic [2*NPROC-1:0]   perm_o,
  output logic [CW-1:0]        cnt_o,
  output logic                 listed_o
);
  perm_e             perm_q [NPROC];
  perm_e             perm_d [NPROC];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              lst_q, lst_d;
  logic              own_nil;
  logic              writer;
  logic              upd_en;
  logic [NPROC-1:0]  held;

  for (genvar i = 0; i < NPROC; i++) begin : g_out
    assign perm_o[2*i +: 2] = perm_q[i];
    assign held[i]          = (perm_q[i] != PR_NIL);
  end

  assign cnt_o    = cnt_q;
  assign listed_o = lst_q;
  assign upd_en   = rd_hit | wr_hit | rv_hit;

  always_comb begin
    writer = 1'b0;
    for (int i = 0; i < NPROC; i++) begin
      writer = writer | (perm_q[i] == PR_WRITE);
    end
  end

  // next-state
  always_comb begin
    for (int i = 0; i < NPROC; i++) perm_d[i] = perm_q[i];
    cnt_d   = cnt_q;
    lst_d   = lst_q;
    own_nil = (perm_q[proc] == PR_NIL);
    if (rd_hit) begin
      if (own_nil) begin
        cnt_d        = cnt_q + CW'(1);
        perm_d[proc] = PR_READ;
        if (writer) lst_d = 1'b1;
      end
    end else if (wr_hit) begin
      if (own_nil) cnt_d = cnt_q + CW'(1);
      perm_d[proc] = PR_WRITE;
      if (cnt_d > CW'(1)) lst_d = 1'b1;
    end else if (rv_hit) begin
      if (!own_nil) begin
        cnt_d        = cnt_q - CW'(1);
        perm_d[proc] = PR_NIL;
        if (cnt_d == '0) lst_d = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROC; i++) perm_q[i] <= PR_NIL;
      cnt_q <= '0;
      lst_q <= 1'b0;
    end else if (upd_en) begin
      for (int i = 0; i < NPROC; i++) perm_q[i] <= perm_d[i];
      cnt_q <= cnt_d;
      lst_q <= lst_d;
    end
  end

  AST_CNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(held) == int'(cnt_q)); // R4
  AST_FLAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lst_q |-> (cnt_q != '0)); // R8
endmodule

// File: rtl/lrc_scan_pick.sv
module lrc_scan_pick #(
  parameter int NPAGE = 8,
  parameter int GW    = 3
) (
  input  logic [NPAGE-1:0] cand,
  input  logic [GW:0]      from,
  output logic             found,
  output logic [GW-1:0]    idx
);
  localparam int GW1 = GW + 1;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = NPAGE - 1; g >= 0; g--) begin
      if (cand[g] && (GW1'(g) >= from)) begin
        found = 1'b1;
        idx   = GW'(g);
      end
    end
  end
endmodule

// File: rtl/lrc_page_tracker.sv
module lrc_page_tracker
  import lrc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NPAGE = 8,
  parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  parameter int GW    = (NPAGE > 1) ? $clog2(NPAGE) : 1,
  parameter int CW    = $clog2(NPROC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [PW-1:0]             cmd_proc,
  input  logic [GW-1:0]             cmd_page,
  output logic                      cmd_done,
  output logic                      busy,
  output logic                      inv_req,
  output logic [PW-1:0]             inv_proc,
  output logic [GW-1:0]             inv_page,
  input  logic                      inv_ack,
  input  logic [NPROC-1:0]          wb_empty,
  output logic [2*NPAGE*NPROC-1:0]  perm_o,
  output logic [NPAGE-1:0]          list_o,
  output logic [NPAGE*CW-1:0]       cnt_o
);
  state_e          st_q, st_d;
  op_e             op_q, op_d;
  logic [PW-1:0]   proc_q, proc_d;
  logic [GW-1:0]   page_q, page_d;
  logic [GW:0]     ptr_q, ptr_d;
  logic            accept;
  logic            rd_evt, wr_evt, rv_evt;
  logic [PW-1:0]   evt_proc;
  logic [GW-1:0]   evt_page;
  logic [NPAGE-1:0] acc_vec, cand;
  logic            pick_found;
  logic [GW-1:0]   pick_idx;

  assign accept   = (st_q == S_IDLE) && cmd_valid;
  assign rd_evt   = accept && (op_e'(cmd_op) == OP_RDF);
  assign wr_evt   = accept && (op_e'(cmd_op) == OP_WRF);
  assign rv_evt   = (st_q == S_INV) && inv_ack;
  assign evt_proc = (st_q == S_IDLE) ? cmd_proc : proc_q;
  assign evt_page = (st_q == S_IDLE) ? cmd_page : page_q;

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    logic hit;
    assign hit = (evt_page == GW'(g));
    lrc_page_slot #(.NPROC(NPROC), .PW(PW), .CW(CW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_hit   (rd_evt && hit),
      .wr_hit   (wr_evt && hit),
      .rv_hit   (rv_evt && hit),
      .proc     (evt_proc),
      .perm_o   (perm_o[g*2*NPROC +: 2*NPROC]),
      .cnt_o    (cnt_o[g*CW +: CW]),
      .listed_o (list_o[g])
    );
    assign acc_vec[g] = |perm_o[g*2*NPROC + 2*proc_q +: 2];
  end

  assign cand = list_o & acc_vec;

  lrc_scan_pick #(.NPAGE(NPAGE), .GW(GW)) u_pick (
    .cand  (cand),
    .from  (ptr_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    proc_d = proc_q;
    page_d = page_q;
    ptr_d  = ptr_q;
    case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          op_d   = op_e'(cmd_op);
          proc_d = cmd_proc;
          page_d = cmd_page;
          ptr_d  = '0;
          case (op_e'(cmd_op))
            OP_ACQ:  st_d = S_SCAN;
            OP_REL:  st_d = S_WAITWB;
            default: st_d = S_RESP;
          endcase
        end
      end
      S_WAITWB: if (wb_empty[proc_q]) st_d = S_RESP;
      S_SCAN: begin
        if (pick_found) begin
          page_d = pick_idx;
          st_d   = S_INV;
        end else begin
          st_d = S_RESP;
        end
      end
      S_INV: begin
        if (inv_ack) begin
          ptr_d = {1'b0, page_q} + 1'b1;
          st_d  = S_SCAN;
        end
      end
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_RDF;
      proc_q <= '0;
      page_q <= '0;
      ptr_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      proc_q <= proc_d;
      page_q <= page_d;
      ptr_q  <= ptr_d;
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign cmd_done  = (st_q == S_RESP);
  assign busy      = (st_q == S_SCAN) || (st_q == S_INV);
  assign inv_req   = (st_q == S_INV);
  assign inv_proc  = proc_q;
  assign inv_page  = page_q;

  AST_INV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_ack) |=> (inv_req && $stable(inv_page))); // R7
  AST_INV_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> (list_o[inv_page] && (perm_o[inv_page*2*NPROC + 2*inv_proc +: 2] != 2'd0))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R6
  AST_REL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && (op_q == OP_REL)) |-> $past(wb_empty[proc_q])); // R10
  AST_DONE_IDLE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy); // R9
endmodule

// File: tb/sim_lrc_page_tracker.sv
`timescale 1ns/1ps
module sim_lrc_page_tracker;
  localparam int NPROC = 4;
  localparam int NPAGE = 8;
  localparam int PW = 2;
  localparam int GW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [PW-1:0] cmd_proc = '0;
  logic [GW-1:0] cmd_page = '0;
  logic cmd_done, busy, inv_req;
  logic [PW-1:0] inv_proc;
  logic [GW-1:0] inv_page;
  logic inv_ack = 1'b0;
  logic [NPROC-1:0] wb_empty = '1;
  logic [2*NPAGE*NPROC-1:0] perm_o;
  logic [NPAGE-1:0] list_o;
  logic [NPAGE*CW-1:0] cnt_o;

  always #2 clk = ~clk;

  lrc_page_tracker #(.NPROC(NPROC), .NPAGE(NPAGE)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_proc(cmd_proc), .cmd_page(cmd_page), .cmd_done(cmd_done),
    .busy(busy), .inv_req(inv_req), .inv_proc(inv_proc), .inv_page(inv_page),
    .inv_ack(inv_ack), .wb_empty(wb_empty), .perm_o(perm_o), .list_o(list_o), .cnt_o(cnt_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [1:0] mperm [NPAGE][NPROC];
  int mcnt [NPAGE];
  logic mlist [NPAGE];

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NPAGE*NPROC-1:0] exp_perm();
    logic [2*NPAGE*NPROC-1:0] v = '0;
    for (int g = 0; g < NPAGE; g++)
      for (int p = 0; p < NPROC; p++) v[(g*NPROC+p)*2 +: 2] = mperm[g][p];
    return v;
  endfunction

  function automatic logic [NPAGE*CW-1:0] exp_cnt();
    logic [NPAGE*CW-1:0] v = '0;
    for (int g = 0; g < NPAGE; g++) v[g*CW +: CW] = CW'(mcnt[g]);
    return v;
  endfunction

  function automatic logic [NPAGE-1:0] exp_list();
    logic [NPAGE-1:0] v = '0;
    for (int g = 0; g < NPAGE; g++) v[g] = mlist[g];
    return v;
  endfunction

  task automatic check_state(string req);
    check({req, " perm"}, 256'(perm_o), 256'(exp_perm()));
    check({req, " cnt"}, 256'(cnt_o), 256'(exp_cnt()));
    check({req, " list"}, 256'(list_o), 256'(exp_list()));
  endtask

  task automatic model_fault(int op, int p, int g);
    logic wr = 1'b0;
    for (int q = 0; q < NPROC; q++) if (mperm[g][q] == 2'd2) wr = 1'b1;
    if (op == 0) begin
      if (mperm[g][p] == 2'd0) begin
        mcnt[g]++;
        mperm[g][p] = 2'd1;
        if (wr) mlist[g] = 1'b1;
      end
    end else begin
      if (mperm[g][p] == 2'd0) mcnt[g]++;
      mperm[g][p] = 2'd2;
      if (mcnt[g] > 1) mlist[g] = 1'b1;
    end
  endtask

  task automatic issue(int op, int p, int g, string req);
    int exp_pg [NPAGE];
    int nexp = 0;
    int k = 0;
    int cycles = 0;
    int d = 0;
    logic raised = 1'b0;
    if (op == 2)
      for (int q = 0; q < NPAGE; q++)
        if (mlist[q] && mperm[q][p] != 2'd0) begin exp_pg[nexp] = q; nexp++; end
    if (op == 3) begin
      d = int'($urandom_range(0, 4));
      wb_empty[p] = 1'b0;
    end
    @(negedge clk);
    check({req, " ready"}, 256'(cmd_ready), 256'(1));
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_proc = PW'(p); cmd_page = GW'(g);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_done && cycles < 200) begin
      if (op == 2) begin
        check("R9 busy during scan", 256'(busy), 256'(1));
        if (inv_req) begin
          check("R7 inv order", 256'({inv_proc, inv_page}), 256'({PW'(p), GW'(k < nexp ? exp_pg[k] : 255)}));
          for (int w = int'($urandom_range(0, 3)); w > 0; w--) begin
            @(negedge clk); cycles++;
            check("R7 inv held", 256'({inv_req, inv_page}), 256'({1'b1, GW'(k < nexp ? exp_pg[k] : 255)}));
          end
          if (k < nexp) begin
            mperm[exp_pg[k]][p] = 2'd0;
            mcnt[exp_pg[k]]--;
            if (mcnt[exp_pg[k]] == 0) mlist[exp_pg[k]] = 1'b0;
          end
          k++;
          inv_ack = 1'b1;
          @(negedge clk); cycles++;
          inv_ack = 1'b0;
          check_state("R8 revoke");
          continue;
        end
      end
      if (op == 3 && cycles == d) begin wb_empty[p] = 1'b1; raised = 1'b1; end
      @(negedge clk); cycles++;
    end
    check({req, " done seen"}, 256'(cmd_done), 256'(1));
    if (op <= 1) begin
      model_fault(op, p, g);
      check("R6 fault done timing", 256'(cycles), 256'(0));
    end
    if (op == 2) begin
      check("R7 inv count", 256'(k), 256'(nexp));
      check("R9 busy at done", 256'(busy), 256'(0));
    end
    if (op == 3) check("R10 done after wb empty", 256'(raised), 256'(1));
    check_state(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < NPAGE; g++) begin
      mcnt[g] = 0; mlist[g] = 1'b0;
      for (int p = 0; p < NPROC; p++) mperm[g][p] = 2'd0;
    end
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    check("R1 ready", 256'({cmd_ready, busy, cmd_done, inv_req}), 256'(4'b1000));
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");
    // directed corners
    issue(0, 0, 0, "R2 read from nil");
    issue(1, 1, 0, "R5 write from nil shared");
    issue(0, 2, 0, "R11 relist listed page");
    issue(1, 0, 0, "R4 upgrade keeps count");
    issue(0, 3, 1, "R2 read no writer");
    issue(1, 3, 1, "R5 sole writer not listed");
    issue(0, 3, 1, "R3 read from holder");
    issue(0, 1, 0, "R3 read from writer");
    issue(2, 3, 0, "R7 acquire nothing listed");
    issue(2, 0, 0, "R8 acquire keeps list");
    issue(2, 2, 0, "R8 acquire second");
    issue(2, 1, 0, "R8 acquire clears list");
    issue(3, 2, 0, "R10 release");
    issue(1, 0, 5, "R5 setup");
    issue(1, 1, 5, "R5 setup");
    issue(1, 1, 2, "R4 setup");
    issue(0, 0, 2, "R2 writer lists");
    issue(2, 1, 0, "R7 multi page acquire");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      int op = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
      issue(op, int'($urandom_range(0, NPROC-1)), int'($urandom_range(0, NPAGE-1)), "R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule